// File: doc/BRIEF.md
# Zero-Suppressing Channel Address Encoder

The block takes the drift-time stream of one front-end link, one channel per accepted beat, 128 channels per event. An internal 7-bit channel counter advances from 0 to 127 as the channels arrive. Each channel whose drift time is non-zero counts as a hit. Its address is stored in a local buffer, and the link's hit count is incremented. The drift value itself is discarded.

After the last channel of an event has arrived, the block sends a variable-length record over a byte stream with a valid/ready handshake. The record starts with the link address and then the hit count. After those two bytes comes one byte per hit channel, holding that channel's address, in ascending channel order. The hit count must lead the record, so the whole event is collected before any byte goes out.

While the record is draining, the input stalls, and the next event is accepted only after the final byte has been taken.

Top module: `zs_addr_enc`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The first byte of each record is the value on link_id, captured when channel 0 of that event is accepted. Later changes of link_id during the event do not affect it.
- R3: The second byte is the number of channels in the event with non-zero drift time (0 to 128).
- R4: Each hit channel produces exactly one byte after the header, equal to its channel address (0 to 127, zero-extended to 8 bits), in ascending order.
- R5: A channel with drift time 0 produces no address byte.
- R6: An event with no hits produces only the two header bytes, with out_last set on the count byte.
- R7: in_ready is 0 from the cycle after the 128th channel is accepted until the last record byte is accepted; in_ready and out_valid are never 1 together.
- R8: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values and out_valid stays 1 in the next cycle.
- R9: out_last is 1 only on the final byte of a record, and only while out_valid is 1.
- R10: An event with all 128 channels hit gives a count byte of 128 followed by addresses 0 through 127.
- R11: out_valid rises in the cycle right after the 128th channel of an event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_id | input | 8 | Link address, captured with channel 0 |
| in_valid | input | 1 | Drift-time beat present |
| in_ready | output | 1 | Block accepts a channel |
| in_drift | input | DRIFT_W (6) | Drift time of the current channel, 0 means no hit |
| out_valid | output | 1 | Record byte present |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Record byte |
| out_last | output | 1 | Final byte of the record |

## Verification
Stimulus goes in and the output is sampled at the falling edge, half a period away from the active edge. The first record byte is due one cycle after the 128th channel is accepted. Each further byte is due one cycle after the previous one is taken, so one cycle per byte while out_ready stays high.

The scoreboard builds the expected bytes for each event from its drift pattern as the event is driven. It compares them at falling edges where valid and ready are both high, so random backpressure never shifts a comparison. It also checks directly, at the falling edge after the final channel, that out_valid has risen and in_ready has fallen. A final check confirms the block is idle once the last record has drained.

// File: rtl/zs_addr_enc.sv
module zs_addr_enc #(
  parameter int CHANNELS = 128,
  parameter int DRIFT_W  = 6,
  parameter int BYTE_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTE_W-1:0]  link_id,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DRIFT_W-1:0] in_drift,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_data,
  output logic               out_last
);
  localparam int ADDR_W = $clog2(CHANNELS);
  localparam int CNT_W  = $clog2(CHANNELS + 1);

  typedef enum logic [1:0] {COLLECT, SEND_LINK, SEND_CNT, SEND_ADDR} state_t;

  state_t             st;
  logic [ADDR_W-1:0]  chan;
  logic [CNT_W-1:0]   hits;
  logic [CNT_W-1:0]   rd;
  logic [BYTE_W-1:0]  link_q;
  logic [ADDR_W-1:0]  addr_mem [CHANNELS];

  wire take  = in_valid && in_ready;
  wire give  = out_valid && out_ready;
  wire hit   = take && (in_drift != '0);
  wire final_ch = (chan == ADDR_W'(CHANNELS - 1));

  assign in_ready  = (st == COLLECT);
  assign out_valid = (st != COLLECT);

  always_comb begin
    case (st)
      SEND_LINK: out_data = link_q;
      SEND_CNT:  out_data = BYTE_W'(hits);
      SEND_ADDR: out_data = BYTE_W'(addr_mem[rd[ADDR_W-1:0]]);
      default:   out_data = '0;
    endcase
  end

  assign out_last = (st == SEND_CNT  && hits == '0) ||
                    (st == SEND_ADDR && rd == hits - 1'b1);

  always_ff @(posedge clk)
    if (hit) addr_mem[hits[ADDR_W-1:0]] <= chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= COLLECT;
      chan   <= '0;
      hits   <= '0;
      rd     <= '0;
      link_q <= '0;
    end else begin
      case (st)
        COLLECT: if (take) begin
          if (chan == '0) link_q <= link_id;
          if (hit) hits <= hits + 1'b1;
          chan <= chan + 1'b1;
          if (final_ch) st <= SEND_LINK;
        end
        SEND_LINK: if (give) st <= SEND_CNT;
        SEND_CNT: if (give) begin
          rd <= '0;
          if (out_last) begin
            st   <= COLLECT;
            hits <= '0;
          end else st <= SEND_ADDR;
        end
        SEND_ADDR: if (give) begin
          rd <= rd + 1'b1;
          if (out_last) begin
            st   <= COLLECT;
            hits <= '0;
          end
        end
        default: st <= COLLECT;
      endcase
    end
  end
endmodule

module zs_addr_enc_chk #(
  parameter int CHANNELS = 128,
  parameter int DRIFT_W  = 6,
  parameter int BYTE_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [BYTE_W-1:0]  link_id,
  input logic               in_valid,
  input logic               in_ready,
  input logic [DRIFT_W-1:0] in_drift,
  input logic               out_valid,
  input logic               out_ready,
  input logic [BYTE_W-1:0]  out_data,
  input logic               out_last
);
  localparam int CNT_W = $clog2(CHANNELS + 3);

  logic [CNT_W-1:0] n_in;
  logic [CNT_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_in <= '0;
      pos  <= '0;
    end else begin
      if (in_valid && in_ready)
        n_in <= (n_in == CNT_W'(CHANNELS - 1)) ? '0 : n_in + 1'b1;
      if (out_valid && out_ready)
        pos <= out_last ? '0 : pos + 1'b1;
    end
  end

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_link_not_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pos == '0 |-> !out_last);

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pos == CNT_W'(1) |-> out_data <= BYTE_W'(CHANNELS));

  assert_empty_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pos == CNT_W'(1) && out_data == '0 |-> out_last);

  assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && n_in == CNT_W'(CHANNELS - 1) |=> out_valid);
endmodule

bind zs_addr_enc zs_addr_enc_chk #(.CHANNELS(CHANNELS), .DRIFT_W(DRIFT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_id(link_id), .in_valid(in_valid),
  .in_ready(in_ready), .in_drift(in_drift), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/zs_addr_enc_test.sv
module zs_addr_enc_test;
  localparam int CH = 128;
  localparam int DW = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] link_id = 0;
  logic in_valid = 0;
  logic [DW-1:0] in_drift = 0;
  logic out_ready = 1;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int tests = 0, fails = 0;
  bit stall_on = 0;
  bit gaps_on = 0;
  logic [DW-1:0] ev [CH];
  logic [7:0] q_data [$];
  bit         q_last [$];
  string      q_tag  [$];

  always #4 clk = ~clk;

  zs_addr_enc uut (
    .clk(clk), .rst_n(rst_n), .link_id(link_id), .in_valid(in_valid),
    .in_ready(in_ready), .in_drift(in_drift), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #1;
    out_ready = stall_on ? ($urandom % 3 != 0) : 1'b1;
  end

  logic [7:0] prev_data;
  bit prev_last, prev_stall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_data == prev_data && out_last == prev_last,
              "R8 hold", int'(out_data), int'(prev_data));
      if (in_ready && out_valid) check(0, "R7 overlap", 1, 0);
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) check(0, "R9 unexpected byte", int'(out_data), -1);
        else begin
          check(out_data == q_data[0], q_tag[0], int'(out_data), int'(q_data[0]));
          check(out_last == q_last[0], "R9 last", int'(out_last), int'(q_last[0]));
          void'(q_data.pop_front()); void'(q_last.pop_front()); void'(q_tag.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  task automatic put(input logic [DW-1:0] d);
    in_valid = 1; in_drift = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_drift = 0;
  endtask

  task automatic run_event(input logic [7:0] link, input string tag, input bit swap_link);
    int nh = 0;
    for (int c = 0; c < CH; c++) if (ev[c] != 0) nh++;
    q_data.push_back(link);      q_last.push_back(0);       q_tag.push_back("R2 link");
    q_data.push_back(8'(nh));    q_last.push_back(nh == 0); q_tag.push_back(nh == 0 ? "R6 count" : "R3 count");
    for (int c = 0, k = 0; c < CH; c++)
      if (ev[c] != 0) begin
        k++;
        q_data.push_back(8'(c)); q_last.push_back(k == nh); q_tag.push_back(tag);
      end
    link_id = link;
    for (int c = 0; c < CH; c++) begin
      put(ev[c]);
      if (c == 0 && swap_link) link_id = ~link;
      if (gaps_on && ($urandom % 4 == 0)) begin @(posedge clk); #1; end
    end
    @(negedge clk);
    check(out_valid == 1, "R11 first byte due", int'(out_valid), 1);
    check(in_ready == 0, "R7 input held", int'(in_ready), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0, "R1 reset", int'({in_ready, out_valid}), 2);
    @(posedge clk); #1;
    rst_n = 1;

    for (int c = 0; c < CH; c++) ev[c] = (c % 9 == 2) ? DW'(c % 5 + 1) : '0;
    run_event(8'h3A, "R4 R5 sparse", 0);

    for (int c = 0; c < CH; c++) ev[c] = '0;
    run_event(8'h05, "R6 none", 0);

    for (int c = 0; c < CH; c++) ev[c] = DW'(c % 63 + 1);
    run_event(8'hFF, "R10 full", 0);

    stall_on = 1; gaps_on = 1;
    for (int c = 0; c < CH; c++) ev[c] = ($urandom % 10 == 0) ? DW'($urandom % 63 + 1) : '0;
    run_event(8'h55, "R4 R5 random", 1);

    for (int c = 0; c < CH; c++) ev[c] = (c == 0 || c == CH - 1) ? DW'(1) : '0;
    run_event(8'h81, "R4 edges", 1);

    for (int c = 0; c < CH; c++) ev[c] = DW'(c % 64);
    run_event(8'h10, "R10 R5 dense", 0);

    while (q_data.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(in_ready == 1 && out_valid == 0, "R7 idle after drain", int'({in_ready, out_valid}), 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule